// File: doc/BRIEF.md
# Transfer Descriptor Fetch Sequencer

This block finds and loads the control descriptor that a data-transfer engine needs before it can move data. An activation carries a 7-bit vector number. The block reads a 2-byte vector table entry for that number and extends it to a 24-bit descriptor start address. It checks that address, then reads three 32-bit words and splits them into two mode bytes, a source address, a destination address and two 16-bit counts. When all three words are in, it raises a one-cycle valid strobe.

Descriptors for a chained transfer sit one after another in memory. If the consumer asks to chain while the valid strobe is high, the block fetches the next descriptor 12 bytes further on. It does not read the vector table again for that descriptor. The memory side is a plain read port with one read outstanding at a time. Each read is a 16-bit or a 32-bit read, and a ready input completes it.

Top module: `dfetch_seq`

## Requirements
- R1: An accepted activation first reads a 16-bit entry (mem_wide_o = 0) at address 0x000400 + 2 × act_vec_i. For example, vector 0x10 reads 0x000420. The entry value is taken from mem_rdata_i[15:0].
- R2: The descriptor start address is the entry value with 0xFF placed above it as the top byte.
- R3: If the start address has either of its low two bits set, the block pulses err_o for one cycle with err_code_o = 1 and makes no descriptor word read. An alignment fault takes precedence over a window fault.
- R4: An aligned start address below 0xFFEBC0 or above 0xFFEFBF pulses err_o with err_code_o = 2 and makes no word read. Both window ends are inclusive and are accepted.
- R5: The descriptor words are read as 32-bit reads (mem_wide_o = 1) at start, start+4 and start+8, in that order.
- R6: Memory is big-endian, so byte 0 is bits 31:24 of a word. From word 0, desc_mra_o = bits 31:24 and desc_sar_o = bits 23:0. From word 1, desc_mrb_o = bits 31:24 and desc_dar_o = bits 23:0. From word 2, desc_cra_o = bits 31:16 and desc_crb_o = bits 15:0.
- R7: After the third word is accepted, desc_vld_o is high for exactly one cycle. The descriptor fields then hold their values until the next descriptor load.
- R8: When chain_i is high in the cycle desc_vld_o is high, the block fetches the next descriptor at start+12 without a vector read. The R3 and R4 checks also apply to that new start address.
- R9: busy_o is high from the cycle after an activation is accepted until the block returns to idle. Activations while busy_o is high are ignored.
- R10: After reset, busy_o, mem_req_o, desc_vld_o and err_o are all low.
- R11: A read request holds its address and width stable until mem_rdy_i completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_i | input | 1 | Activation strobe |
| act_vec_i | input | 7 | Vector number sampled with act_i |
| chain_i | input | 1 | Fetch the following descriptor; sampled while desc_vld_o is high |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 24 | Read byte address |
| mem_wide_o | output | 1 | 1 = 32-bit read, 0 = 16-bit read |
| mem_rdy_i | input | 1 | Read completes at this clock edge |
| mem_rdata_i | input | 32 | Read data, valid while mem_rdy_i is high |
| busy_o | output | 1 | Fetch in progress |
| desc_vld_o | output | 1 | Descriptor complete, one cycle |
| desc_mra_o | output | 8 | First mode byte |
| desc_sar_o | output | 24 | Source address |
| desc_mrb_o | output | 8 | Second mode byte |
| desc_dar_o | output | 24 | Destination address |
| desc_cra_o | output | 16 | First count |
| desc_crb_o | output | 16 | Second count |
| err_o | output | 1 | Fault pulse, one cycle |
| err_code_o | output | 2 | Cause of the last fault: 1 alignment, 2 window |

## Verification
The assertions assume that the memory port keeps the protocol. mem_rdy_i is high only while a request is pending, and mem_rdata_i is valid in that same cycle. They also assume that chain_i matters only while desc_vld_o is high. The bench's memory model responds only to a pending request and inserts a programmable number of wait cycles. It returns vector entries in the low half of the data bus. The bench drives chain_i and act_i for single cycles at the falling edge. The extra activation in the ignore test is placed inside a fetch that has been stretched by wait states.

// File: rtl/dfetch_pkg.sv
package dfetch_pkg;
   localparam int A_W      = 24;
   localparam int WORD_W   = 32;
   localparam int ENTRY_W  = 16;
   localparam int MODE_W   = 8;
   localparam int CNT_W    = 16;
   localparam int N_WORDS  = 3;
   localparam int DESC_BYTES = N_WORDS * (WORD_W / 8);

   typedef enum logic [2:0] {
      ST_IDLE, ST_VEC, ST_CHK, ST_W0, ST_W1, ST_W2, ST_DONE, ST_ERR
   } dfetch_state_e;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_ALIGN = 2'd1,
      FLT_RANGE = 2'd2
   } dfetch_fault_e;

   typedef struct packed {
      logic [MODE_W-1:0] mra;
      logic [A_W-1:0]    sar;
      logic [MODE_W-1:0] mrb;
      logic [A_W-1:0]    dar;
      logic [CNT_W-1:0]  cra;
      logic [CNT_W-1:0]  crb;
   } dfetch_desc_t;
endpackage

// File: rtl/dfetch_ctrl.sv
module dfetch_ctrl
   import dfetch_pkg::*;
#(
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_i,
   input  logic          chain_i,
   input  logic          rdy_i,
   input  logic          bad_align_i,
   input  logic          bad_range_i,
   output dfetch_state_e state_o,
   output logic          accept_o,
   output logic          ld_start_o,
   output logic          step_o,
   output logic [N_WORDS-1:0] ld_word_o,
   output logic          fault_o
);
   dfetch_state_e st_q, st_d;
   logic chain_ok;

   generate
      if (CHAIN_EN) begin : g_chain
         assign chain_ok = chain_i;
      end else begin : g_nochain
         assign chain_ok = 1'b0;
      end
   endgenerate

   assign accept_o   = (st_q == ST_IDLE) && act_i;
   assign ld_start_o = (st_q == ST_VEC) && rdy_i;
   assign step_o     = (st_q == ST_DONE) && chain_ok;
   assign fault_o    = (st_q == ST_CHK) && (bad_align_i || bad_range_i);
   assign ld_word_o[0] = (st_q == ST_W0) && rdy_i;
   assign ld_word_o[1] = (st_q == ST_W1) && rdy_i;
   assign ld_word_o[2] = (st_q == ST_W2) && rdy_i;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (act_i) st_d = ST_VEC;
         ST_VEC:  if (rdy_i) st_d = ST_CHK;
         ST_CHK:  st_d = (bad_align_i || bad_range_i) ? ST_ERR : ST_W0;
         ST_W0:   if (rdy_i) st_d = ST_W1;
         ST_W1:   if (rdy_i) st_d = ST_W2;
         ST_W2:   if (rdy_i) st_d = ST_DONE;
         ST_DONE: st_d = chain_ok ? ST_CHK : ST_IDLE;
         ST_ERR:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state_o = st_q;
endmodule

// File: rtl/dfetch_addr.sv
module dfetch_addr
   import dfetch_pkg::*;
#(
   parameter int             VEC_NUM_W = 7,
   parameter logic [A_W-1:0] VEC_BASE  = 24'h000400,
   parameter logic [A_W-1:0] RAM_LO    = 24'hFFEBC0,
   parameter logic [A_W-1:0] RAM_HI    = 24'hFFEFBF,
   parameter bit             CHECK_RANGE = 1'b1
) (
   input  dfetch_state_e        state_i,
   input  logic [VEC_NUM_W-1:0] vec_i,
   input  logic [A_W-1:0]       start_i,
   output logic [A_W-1:0]       addr_o,
   output logic                 wide_o,
   output logic                 req_o,
   output logic                 bad_align_o,
   output logic                 bad_range_o
);
   localparam int WB = WORD_W / 8;
   logic [A_W-1:0] vec_addr;

   assign vec_addr = VEC_BASE + A_W'({vec_i, 1'b0});

   always_comb begin
      unique case (state_i)
         ST_W0:   addr_o = start_i;
         ST_W1:   addr_o = start_i + A_W'(WB);
         ST_W2:   addr_o = start_i + A_W'(2 * WB);
         default: addr_o = vec_addr;
      endcase
   end

   assign wide_o = (state_i == ST_W0) || (state_i == ST_W1) || (state_i == ST_W2);
   assign req_o  = wide_o || (state_i == ST_VEC);
   assign bad_align_o = |start_i[1:0];

   generate
      if (CHECK_RANGE) begin : g_range
         assign bad_range_o = (start_i < RAM_LO) || (start_i > RAM_HI);
      end else begin : g_norange
         assign bad_range_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dfetch_unpack.sv
module dfetch_unpack
   import dfetch_pkg::*;
(
   input  logic [N_WORDS-1:0][WORD_W-1:0] words_i,
   output dfetch_desc_t                   desc_o
);
   assign desc_o.mra = words_i[0][WORD_W-1 -: MODE_W];
   assign desc_o.sar = words_i[0][A_W-1:0];
   assign desc_o.mrb = words_i[1][WORD_W-1 -: MODE_W];
   assign desc_o.dar = words_i[1][A_W-1:0];
   assign desc_o.cra = words_i[2][WORD_W-1 -: CNT_W];
   assign desc_o.crb = words_i[2][CNT_W-1:0];
endmodule

// File: rtl/dfetch_seq.sv
module dfetch_seq
   import dfetch_pkg::*;
#(
   parameter int             VEC_NUM_W   = 7,
   parameter logic [A_W-1:0] VEC_BASE    = 24'h000400,
   parameter logic [A_W-1:0] RAM_LO      = 24'hFFEBC0,
   parameter logic [A_W-1:0] RAM_HI      = 24'hFFEFBF,
   parameter logic [7:0]     PAGE_HI     = 8'hFF,
   parameter bit             CHECK_RANGE = 1'b1,
   parameter bit             CHAIN_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_i,
   input  logic [6:0]        act_vec_i,
   input  logic              chain_i,
   output logic              mem_req_o,
   output logic [23:0]       mem_addr_o,
   output logic              mem_wide_o,
   input  logic              mem_rdy_i,
   input  logic [31:0]       mem_rdata_i,
   output logic              busy_o,
   output logic              desc_vld_o,
   output logic [7:0]        desc_mra_o,
   output logic [23:0]       desc_sar_o,
   output logic [7:0]        desc_mrb_o,
   output logic [23:0]       desc_dar_o,
   output logic [15:0]       desc_cra_o,
   output logic [15:0]       desc_crb_o,
   output logic              err_o,
   output logic [1:0]        err_code_o
);
   generate
      if (VEC_NUM_W != 7) begin : g_bad_vec
         $error("dfetch_seq: port act_vec_i is 7 bits wide");
      end
      if (ENTRY_W + 8 != A_W) begin : g_bad_entry
         $error("dfetch_seq: entry plus page byte must fill the address");
      end
      if (RAM_LO[1:0] != 2'b00 || RAM_LO > RAM_HI) begin : g_bad_win
         $error("dfetch_seq: descriptor window malformed");
      end
   endgenerate

   dfetch_state_e        state;
   logic                 accept, ld_start, step, fault;
   logic [N_WORDS-1:0]   ld_word;
   logic                 bad_align, bad_range;
   logic [VEC_NUM_W-1:0] vec_q;
   logic [A_W-1:0]       start_q;
   logic [N_WORDS-1:0][WORD_W-1:0] words_q;
   dfetch_fault_e        code_q;
   dfetch_desc_t         desc;

   dfetch_ctrl #(.CHAIN_EN(CHAIN_EN)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .act_i(act_i), .chain_i(chain_i),
      .rdy_i(mem_rdy_i), .bad_align_i(bad_align), .bad_range_i(bad_range),
      .state_o(state), .accept_o(accept), .ld_start_o(ld_start),
      .step_o(step), .ld_word_o(ld_word), .fault_o(fault)
   );

   dfetch_addr #(
      .VEC_NUM_W(VEC_NUM_W), .VEC_BASE(VEC_BASE), .RAM_LO(RAM_LO),
      .RAM_HI(RAM_HI), .CHECK_RANGE(CHECK_RANGE)
   ) addr_i (
      .state_i(state), .vec_i(vec_q), .start_i(start_q),
      .addr_o(mem_addr_o), .wide_o(mem_wide_o), .req_o(mem_req_o),
      .bad_align_o(bad_align), .bad_range_o(bad_range)
   );

   dfetch_unpack unpack_i (.words_i(words_q), .desc_o(desc));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q   <= '0;
         start_q <= '0;
         code_q  <= FLT_NONE;
      end else begin
         if (accept)   vec_q   <= act_vec_i;
         if (ld_start) start_q <= {PAGE_HI, mem_rdata_i[ENTRY_W-1:0]};
         else if (step) start_q <= start_q + A_W'(DESC_BYTES);
         if (fault)    code_q  <= bad_align ? FLT_ALIGN : FLT_RANGE;
      end
   end

   for (genvar k = 0; k < N_WORDS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          words_q[k] <= '0;
         else if (ld_word[k]) words_q[k] <= mem_rdata_i;
      end
   end

   assign busy_o     = (state != ST_IDLE);
   assign desc_vld_o = (state == ST_DONE);
   assign err_o      = (state == ST_ERR);
   assign err_code_o = code_q;
   assign desc_mra_o = desc.mra;
   assign desc_sar_o = desc.sar;
   assign desc_mrb_o = desc.mrb;
   assign desc_dar_o = desc.dar;
   assign desc_cra_o = desc.cra;
   assign desc_crb_o = desc.crb;
endmodule

// File: rtl/dfetch_seq_chk.sv
module dfetch_seq_chk #(
   parameter int          VEC_NUM_W = 7,
   parameter logic [23:0] VEC_BASE  = 24'h000400,
   parameter logic [23:0] RAM_LO    = 24'hFFEBC0,
   parameter logic [23:0] RAM_HI    = 24'hFFEFBF
) (
   input logic        clk,
   input logic        rst_n,
   input logic        act_i,
   input logic [6:0]  act_vec_i,
   input logic        chain_i,
   input logic        mem_req_o,
   input logic [23:0] mem_addr_o,
   input logic        mem_wide_o,
   input logic        mem_rdy_i,
   input logic [31:0] mem_rdata_i,
   input logic        busy_o,
   input logic        desc_vld_o,
   input logic [7:0]  desc_mra_o,
   input logic [23:0] desc_sar_o,
   input logic [7:0]  desc_mrb_o,
   input logic [23:0] desc_dar_o,
   input logic [15:0] desc_cra_o,
   input logic [15:0] desc_crb_o,
   input logic        err_o,
   input logic [1:0]  err_code_o
);
   localparam logic [23:0] VEC_LAST = 24'(VEC_BASE + (2 ** (VEC_NUM_W + 1)) - 2);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wide_o)); // R11
   AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_wide_o |-> !mem_addr_o[0] && mem_addr_o >= VEC_BASE && mem_addr_o <= VEC_LAST); // R1
   AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_wide_o |-> mem_addr_o[1:0] == 2'b00); // R5
   AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      desc_vld_o |=> !desc_vld_o); // R7
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o && !busy_o); // R3
   AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> err_code_o == 2'd1 || err_code_o == 2'd2); // R4
   AST_VLD_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !(desc_vld_o && err_o)); // R3
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_o && !desc_vld_o && !err_o); // R9
   AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && $past(!busy_o) |-> $stable(desc_sar_o) && $stable(desc_dar_o) && $stable(desc_cra_o)); // R7
   AST_BUSY_ON_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && act_i |=> busy_o && mem_req_o && !mem_wide_o); // R9
endmodule

bind dfetch_seq dfetch_seq_chk #(
   .VEC_NUM_W(VEC_NUM_W), .VEC_BASE(VEC_BASE), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)
) chk_i (.*);

// File: tb/dfetch_seq_tb_top.sv
module dfetch_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        act_i = 1'b0;
   logic [6:0]  act_vec_i = '0;
   logic        chain_i = 1'b0;
   logic        mem_req_o, mem_wide_o, mem_rdy_i;
   logic [23:0] mem_addr_o;
   logic [31:0] mem_rdata_i;
   logic        busy_o, desc_vld_o, err_o;
   logic [7:0]  desc_mra_o, desc_mrb_o;
   logic [23:0] desc_sar_o, desc_dar_o;
   logic [15:0] desc_cra_o, desc_crb_o;
   logic [1:0]  err_code_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   dfetch_seq dut_i (.*);

   // memory model
   logic [15:0] vtab [128];
   logic [7:0]  ram  [1024];
   int          lat = 0;
   int          wcnt = 0;
   logic [23:0] log_a [16];
   logic        log_w [16];
   int          log_n = 0;

   function automatic logic [31:0] mem_read(logic [23:0] a, logic w);
      int o;
      if (!w) begin
         if (a >= 24'h000400 && a <= 24'h0004FF) return {16'h0, vtab[(a - 24'h000400) >> 1]};
         return 32'h0000DEAD;
      end
      if (a >= 24'hFFEBC0 && a <= 24'hFFEFBC) begin
         o = int'(a - 24'hFFEBC0);
         return {ram[o], ram[o+1], ram[o+2], ram[o+3]};
      end
      return 32'hDEADBEEF;
   endfunction

   initial begin
      mem_rdy_i = 1'b0;
      mem_rdata_i = '0;
   end

   always @(negedge clk) begin
      cycles++;
      mem_rdy_i <= 1'b0;
      if (rst_n && mem_req_o) begin
         if (wcnt >= lat) begin
            mem_rdy_i   <= 1'b1;
            mem_rdata_i <= mem_read(mem_addr_o, mem_wide_o);
            if (log_n < 16) begin
               log_a[log_n] = mem_addr_o;
               log_w[log_n] = mem_wide_o;
            end
            log_n++;
            wcnt = 0;
         end else wcnt++;
      end else wcnt = 0;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put_desc(input logic [23:0] a, input logic [7:0] ma, input logic [23:0] sa,
                           input logic [7:0] mb, input logic [23:0] da,
                           input logic [15:0] ca, input logic [15:0] cb);
      logic [95:0] img;
      int o;
      img = {ma, sa, mb, da, ca, cb};
      o = int'(a - 24'hFFEBC0);
      for (int i = 0; i < 12; i++) ram[o+i] = img[95-8*i -: 8];
   endtask

   task automatic activate(input logic [6:0] v);
      @(negedge clk);
      @(negedge clk);
      log_n = 0;
      act_i = 1'b1;
      act_vec_i = v;
      @(negedge clk);
      act_i = 1'b0;
   endtask

   task automatic wait_end();
      for (int i = 0; i < 200; i++) begin
         if (desc_vld_o || err_o) break;
         @(negedge clk);
      end
   endtask

   task automatic chk_fields(input string tag, input logic [7:0] ma, input logic [23:0] sa,
                             input logic [7:0] mb, input logic [23:0] da,
                             input logic [15:0] ca, input logic [15:0] cb);
      chk(desc_mra_o == ma, {tag, " mra"}, 32'(desc_mra_o), 32'(ma));
      chk(desc_sar_o == sa, {tag, " sar"}, 32'(desc_sar_o), 32'(sa));
      chk(desc_mrb_o == mb, {tag, " mrb"}, 32'(desc_mrb_o), 32'(mb));
      chk(desc_dar_o == da, {tag, " dar"}, 32'(desc_dar_o), 32'(da));
      chk(desc_cra_o == ca, {tag, " cra"}, 32'(desc_cra_o), 32'(ca));
      chk(desc_crb_o == cb, {tag, " crb"}, 32'(desc_crb_o), 32'(cb));
   endtask

   task automatic t_reset();
      chk(!busy_o && !mem_req_o && !desc_vld_o && !err_o, "R10 reset outputs",
          {28'h0, busy_o, mem_req_o, desc_vld_o, err_o}, 32'h0);
   endtask

   task automatic t_basic();
      lat = 0;
      vtab[7'h10] = 16'hEC40;
      put_desc(24'hFFEC40, 8'hA5, 24'h123456, 8'h3C, 24'hFEDCBA, 16'h0102, 16'hF00D);
      activate(7'h10);
      chk(busy_o == 1'b1, "R9 busy after accept", 32'(busy_o), 32'h1);
      wait_end();
      chk(desc_vld_o == 1'b1, "R7 valid raised", 32'(desc_vld_o), 32'h1);
      chk(log_a[0] == 24'h000420 && !log_w[0], "R1 vector read", 32'(log_a[0]), 32'h420);
      chk(log_a[1] == 24'hFFEC40 && log_w[1], "R2 R5 word0 addr", 32'(log_a[1]), 32'hFFEC40);
      chk(log_a[2] == 24'hFFEC44 && log_w[2], "R5 word1 addr", 32'(log_a[2]), 32'hFFEC44);
      chk(log_a[3] == 24'hFFEC48 && log_w[3], "R5 word2 addr", 32'(log_a[3]), 32'hFFEC48);
      chk(log_n == 4, "R5 read count", 32'(log_n), 32'd4);
      chk_fields("R6 basic", 8'hA5, 24'h123456, 8'h3C, 24'hFEDCBA, 16'h0102, 16'hF00D);
      @(negedge clk);
      chk(desc_vld_o == 1'b0, "R7 valid one cycle", 32'(desc_vld_o), 32'h0);
      chk(busy_o == 1'b0, "R9 idle after", 32'(busy_o), 32'h0);
      repeat (3) @(negedge clk);
      chk_fields("R7 hold", 8'hA5, 24'h123456, 8'h3C, 24'hFEDCBA, 16'h0102, 16'hF00D);
   endtask

   task automatic t_low_edge_waits();
      lat = 2;
      vtab[7'h7F] = 16'hEBC0;
      put_desc(24'hFFEBC0, 8'h01, 24'h00FFEE, 8'h80, 24'h7F0011, 16'hFFFF, 16'h0000);
      activate(7'h7F);
      wait_end();
      chk(desc_vld_o == 1'b1, "R4 low window end accepted", 32'(desc_vld_o), 32'h1);
      chk(log_a[0] == 24'h0004FE, "R1 top vector", 32'(log_a[0]), 32'h4FE);
      chk_fields("R6 waits", 8'h01, 24'h00FFEE, 8'h80, 24'h7F0011, 16'hFFFF, 16'h0000);
      lat = 0;
   endtask

   task automatic t_fault(input logic [6:0] v, input logic [15:0] ent, input logic [1:0] code,
                          input string tag);
      vtab[v] = ent;
      activate(v);
      wait_end();
      chk(err_o == 1'b1 && desc_vld_o == 1'b0, {tag, " err pulse"}, 32'(err_o), 32'h1);
      chk(err_code_o == code, {tag, " code"}, 32'(err_code_o), 32'(code));
      chk(log_n == 1, {tag, " no word read"}, 32'(log_n), 32'd1);
      @(negedge clk);
      chk(!err_o && !busy_o, {tag, " back idle"}, {30'h0, err_o, busy_o}, 32'h0);
   endtask

   task automatic t_chain();
      vtab[7'h06] = 16'hEC00;
      put_desc(24'hFFEC00, 8'h11, 24'h111111, 8'h22, 24'h222222, 16'h3333, 16'h4444);
      put_desc(24'hFFEC0C, 8'h55, 24'h666666, 8'h77, 24'h888888, 16'h9999, 16'hAAAA);
      activate(7'h06);
      wait_end();
      chk_fields("R8 first", 8'h11, 24'h111111, 8'h22, 24'h222222, 16'h3333, 16'h4444);
      chain_i = 1'b1;
      @(negedge clk);
      chain_i = 1'b0;
      wait_end();
      chk(desc_vld_o == 1'b1, "R8 second valid", 32'(desc_vld_o), 32'h1);
      chk_fields("R8 second", 8'h55, 24'h666666, 8'h77, 24'h888888, 16'h9999, 16'hAAAA);
      chk(log_n == 7 && log_a[4] == 24'hFFEC0C && log_w[4], "R8 no vector reread",
          32'(log_a[4]), 32'hFFEC0C);
   endtask

   task automatic t_chain_out();
      vtab[7'h08] = 16'hEFB4;
      put_desc(24'hFFEFB4, 8'h0F, 24'hABCDEF, 8'hF0, 24'h012345, 16'h0001, 16'h0002);
      activate(7'h08);
      wait_end();
      chk_fields("R4 top desc", 8'h0F, 24'hABCDEF, 8'hF0, 24'h012345, 16'h0001, 16'h0002);
      chain_i = 1'b1;
      @(negedge clk);
      chain_i = 1'b0;
      wait_end();
      chk(err_o == 1'b1 && err_code_o == 2'd2, "R8 R4 chain leaves window",
          32'(err_code_o), 32'd2);
      chk(log_n == 4, "R8 no read after fault", 32'(log_n), 32'd4);
   endtask

   task automatic t_ignore();
      lat = 3;
      vtab[7'h20] = 16'hED00;
      vtab[7'h21] = 16'hEE00;
      put_desc(24'hFFED00, 8'hC1, 24'hC2C3C4, 8'hC5, 24'hC6C7C8, 16'hC9CA, 16'hCBCC);
      put_desc(24'hFFEE00, 8'hD1, 24'hD2D3D4, 8'hD5, 24'hD6D7D8, 16'hD9DA, 16'hDBDC);
      activate(7'h20);
      act_i = 1'b1;
      act_vec_i = 7'h21;
      @(negedge clk);
      act_i = 1'b0;
      wait_end();
      chk_fields("R9 ignored act", 8'hC1, 24'hC2C3C4, 8'hC5, 24'hC6C7C8, 16'hC9CA, 16'hCBCC);
      @(negedge clk);
      chk(log_n == 4 && log_a[0] == 24'h000440, "R9 single vector read", 32'(log_n), 32'd4);
      lat = 0;
   endtask

   initial begin
      for (int i = 0; i < 128; i++) vtab[i] = 16'h0000;
      for (int i = 0; i < 1024; i++) ram[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_basic();
      t_low_edge_waits();
      t_fault(7'h03, 16'hEBC2, 2'd1, "R3 misaligned");
      t_fault(7'h04, 16'h0000, 2'd2, "R4 below window");
      t_fault(7'h05, 16'hEFC0, 2'd2, "R4 above window");
      t_fault(7'h09, 16'h0001, 2'd1, "R3 precedence");
      t_chain();
      t_chain_out();
      t_ignore();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule